// File: doc/BRIEF.md
# Transmit Bit Source with Test Patterns and Scrambler

This block forms the serial transmit bit stream that goes to the modulator's bit-grouping encoder. On every bit-enable it picks one source bit, then either scrambles that bit or routes it around the scrambler, and registers the result. The source is either the live serial data input or one of three fixed patterns: a mark/space sequence that alternates on each bit (used for link testing and for handshake sequences), a steady mark, or a steady space.

The scrambler is self-synchronizing. Each scrambled bit is the source bit XOR the scrambled bits sent 14 and 17 bit times earlier, which gives the polynomial 1 + x^-14 + x^-17. Pattern selection happens before the scrambler, so a fixed pattern is scrambled too unless bypass is set. The bypass control does not change the pattern selection or the phase of the alternating sequence.

The pattern source is a small state machine. Its states record which bit kind went out on the last bit-enable:

- `PS_LIVE`: live data was sent.
- `PS_ALT_MARK`: the alternating pattern sent a mark.
- `PS_ALT_SPACE`: the alternating pattern sent a space.
- `PS_MARK`: constant mark was sent.
- `PS_SPACE`: constant space was sent.

The transitions are taken only on a bit-enable, and the target depends on the selection code at that bit-enable:

- Code 00 goes to `PS_LIVE`.
- Code 10 goes to `PS_MARK`.
- Code 11 goes to `PS_SPACE`.
- Code 01 goes from `PS_ALT_MARK` to `PS_ALT_SPACE`. From every other state, code 01 goes to `PS_ALT_MARK`, so the pattern starts with a mark.

Synchronous reset puts the machine in `PS_LIVE`.

Top module: `txp_tx_bitpath`

## Requirements
- R1: Synchronous reset clears the output bit to 0 and every scrambler history bit to 0. After reset, a space source with bypass clear therefore produces 0 on the first 14 bit-enables.
- R2: With select code 00 and bypass set, the output after a bit-enable equals the `txd` value sampled at that bit-enable.
- R3: Select code 01 produces a sequence that alternates on every bit-enable. The first bit after code 01 is taken at a bit-enable, following any other code, is mark (1).
- R4: Select code 10 produces constant mark (1).
- R5: Select code 11 produces constant space (0).
- R6: With bypass clear, the output is the source bit XOR the scrambled outputs of 14 and 17 scrambled bits earlier. The history advances only on bit-enables with bypass clear and holds on bypassed ones.
- R7: A cycle without bit-enable leaves the output bit, the pattern state and the scrambler history unchanged.
- R8: Toggling bypass does not restart or disturb the alternating pattern's phase or the selection.
- R9: The output register updates one clock after the bit-enable cycle in which the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe per transmitted bit |
| txd | input | 1 | Live serial transmit data |
| pat_sel | input | 2 | Source select: 00 data, 01 alternating, 10 mark, 11 space |
| scr_bypass | input | 1 | 1 routes the bit around the scrambler |
| tx_bit | output | 1 | Registered transmit bit |

## Verification
The directed steps try each select code with bypass set, so each source can be seen bare. Constant mark and space tell the two fixed patterns apart. A run of code 01, broken by another code, shows that the alternation restarts with a mark.

After reset, a space source with bypass clear shows that the scrambler history starts at zero. Long random runs then mix all codes, sparse bit-enables and bypass toggles. These runs separate correct tap positions and history freezing from near variants: an off-by-one tap, history that advances while bypassed, or an alternating phase that resets on a bypass change.

// File: rtl/txp_pkg.sv
package txp_pkg;

    // Source select codes
    localparam logic [1:0] SEL_DATA  = 2'b00;
    localparam logic [1:0] SEL_ALT   = 2'b01;
    localparam logic [1:0] SEL_MARK  = 2'b10;
    localparam logic [1:0] SEL_SPACE = 2'b11;

    // Last bit kind sent by the pattern source
    typedef enum logic [2:0] {
        PS_LIVE      = 3'd0,
        PS_ALT_MARK  = 3'd1,
        PS_ALT_SPACE = 3'd2,
        PS_MARK      = 3'd3,
        PS_SPACE     = 3'd4
    } pat_state_t;

endpackage

// File: rtl/txp_pattern_fsm.sv
module txp_pattern_fsm
    import txp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       txd,
    input  logic [1:0] pat_sel,
    output logic       pat_bit
);

    pat_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_LIVE;
        end else if (bit_en) begin
            state_q <= state_d;
        end
    end

    // Source bit and next state
    always_comb begin
        pat_bit = 1'b0;
        state_d = state_q;
        unique case (pat_sel)
            SEL_DATA: begin
                pat_bit = txd;
                state_d = PS_LIVE;
            end
            SEL_ALT: begin
                if (state_q == PS_ALT_MARK) begin
                    pat_bit = 1'b0;
                    state_d = PS_ALT_SPACE;
                end else begin
                    pat_bit = 1'b1;
                    state_d = PS_ALT_MARK;
                end
            end
            SEL_MARK: begin
                pat_bit = 1'b1;
                state_d = PS_MARK;
            end
            SEL_SPACE: begin
                pat_bit = 1'b0;
                state_d = PS_SPACE;
            end
            default: begin
                pat_bit = 1'b0;
                state_d = PS_LIVE;
            end
        endcase
    end

    // R3: a mark on the alternating source is followed by a space
    a_r3_alt_toggles: assert property (@(posedge clk) disable iff (rst)
        (bit_en && pat_sel == SEL_ALT && state_q == PS_ALT_MARK) |=> (state_q == PS_ALT_SPACE));

    // R7: the state holds without a bit-enable
    a_r7_state_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(state_q));

endmodule

// File: rtl/txp_scrambler.sv
module txp_scrambler #(
    parameter int TAP_NEAR = 14,
    parameter int TAP_FAR  = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bypass,
    input  logic din,
    output logic dout
);

    localparam int HIST_LEN = TAP_FAR;

    logic [HIST_LEN-1:0] hist_q;
    logic                fb;

    assign fb   = din ^ hist_q[TAP_NEAR-1] ^ hist_q[TAP_FAR-1];
    assign dout = bypass ? din : fb;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (en && !bypass) begin
            hist_q <= {hist_q[HIST_LEN-2:0], fb};
        end
    end

    // R1: reset leaves an empty history
    a_r1_hist_cleared: assert property (@(posedge clk)
        rst |=> (hist_q == '0));

    // R6: history holds on bypassed or idle cycles
    a_r6_hist_frozen: assert property (@(posedge clk) disable iff (rst)
        (!en || bypass) |=> $stable(hist_q));

    // R6: history shifts by one position on a scrambled bit
    a_r6_hist_shift: assert property (@(posedge clk) disable iff (rst)
        (en && !bypass) |=> (hist_q[HIST_LEN-1:1] == $past(hist_q[HIST_LEN-2:0])));

endmodule

// File: rtl/txp_tx_bitpath.sv
module txp_tx_bitpath
    import txp_pkg::*;
#(
    parameter int TAP_NEAR = 14,
    parameter int TAP_FAR  = 17
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       txd,
    input  logic [1:0] pat_sel,
    input  logic       scr_bypass,
    output logic       tx_bit
);

    logic pat_bit;
    logic scr_bit;

    txp_pattern_fsm u_pat (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .txd     (txd),
        .pat_sel (pat_sel),
        .pat_bit (pat_bit)
    );

    txp_scrambler #(
        .TAP_NEAR (TAP_NEAR),
        .TAP_FAR  (TAP_FAR)
    ) u_scr (
        .clk    (clk),
        .rst    (rst),
        .en     (bit_en),
        .bypass (scr_bypass),
        .din    (pat_bit),
        .dout   (scr_bit)
    );

    // R9: output register
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_bit <= 1'b0;
        end else if (bit_en) begin
            tx_bit <= scr_bit;
        end
    end

    a_r1_out_cleared: assert property (@(posedge clk)
        rst |=> !tx_bit);

    a_r2_live_passes: assert property (@(posedge clk) disable iff (rst)
        (bit_en && scr_bypass && pat_sel == SEL_DATA) |=> (tx_bit == $past(txd)));

    a_r4_mark_high: assert property (@(posedge clk) disable iff (rst)
        (bit_en && scr_bypass && pat_sel == SEL_MARK) |=> tx_bit);

    a_r5_space_low: assert property (@(posedge clk) disable iff (rst)
        (bit_en && scr_bypass && pat_sel == SEL_SPACE) |=> !tx_bit);

    a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_bit));

endmodule

// File: tb/txp_tx_bitpath_tb.sv
module txp_tx_bitpath_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       txd = 1'b0;
    logic [1:0] pat_sel = 2'b00;
    logic       scr_bypass = 1'b1;
    logic       tx_bit;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [16:0] m_hist;
    logic        m_out;
    bit          m_last_alt;
    bit          m_last_alt_bit;

    always #(CLK_PERIOD/2) clk = ~clk;

    txp_tx_bitpath dut_i (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .txd        (txd),
        .pat_sel    (pat_sel),
        .scr_bypass (scr_bypass),
        .tx_bit     (tx_bit)
    );

    function automatic logic src_bit(input logic [1:0] sel, input logic d,
                                     input bit last_alt, input bit last_bit);
        case (sel)
            2'b00:   return d;
            2'b01:   return (last_alt && last_bit) ? 1'b0 : 1'b1;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (tx_bit !== exp) begin
            n_fail++;
            $display("FAIL %s: tx_bit=%b expected=%b at %0t", req, tx_bit, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hist = '0;
        m_out = 1'b0;
        m_last_alt = 1'b0;
        m_last_alt_bit = 1'b0;
    endtask

    // Drive one cycle, update the model, check the output after the edge
    task automatic step(input logic en, input logic d, input logic [1:0] sel,
                        input logic byp, input string req);
        logic p;
        logic s;
        @(negedge clk);
        bit_en = en; txd = d; pat_sel = sel; scr_bypass = byp;
        if (en) begin
            p = src_bit(sel, d, m_last_alt, m_last_alt_bit);
            if (byp) begin
                s = p;
            end else begin
                s = p ^ m_hist[13] ^ m_hist[16];
                m_hist = {m_hist[15:0], s};
            end
            m_out = s;
            m_last_alt = (sel == 2'b01);
            m_last_alt_bit = p;
        end
        @(posedge clk);
        #1;
        check(req, m_out);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: expired, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
        check("R1 reset output", 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1: an empty history gives zeros for a space source when scrambled
        for (int i = 0; i < 14; i++) step(1, 0, 2'b11, 0, "R1 cleared history");

        // Fixed sources, bypassed
        step(1, 0, 2'b10, 1, "R4 mark");
        step(1, 1, 2'b11, 1, "R5 space");
        step(1, 1, 2'b00, 1, "R2 live one");
        step(1, 0, 2'b00, 1, "R2 live zero");
        step(0, 1, 2'b00, 1, "R9 no update without strobe");

        // R3: alternation starts with a mark and toggles
        for (int i = 0; i < 4; i++) step(1, 0, 2'b01, 1, "R3 alternate");
        step(1, 0, 2'b10, 1, "R4 mark between");
        step(1, 0, 2'b01, 1, "R3 restart at mark");
        step(0, 0, 2'b01, 1, "R7 hold idle");
        step(1, 0, 2'b01, 1, "R3 space after idle");

        // R8: bypass toggles keep the phase
        step(1, 0, 2'b01, 0, "R8 scrambled alt");
        step(1, 0, 2'b01, 1, "R8 alt after bypass change");
        step(1, 0, 2'b01, 1, "R8 alt continues");

        // R6: scrambled mark source
        for (int i = 0; i < 40; i++) step(1, 0, 2'b10, 0, "R6 scrambled mark");

        // Random mix
        for (int i = 0; i < 5000; i++) begin
            logic en;
            logic byp;
            en  = ($urandom % 4) != 0;
            byp = ($urandom % 8) == 0;
            step(en, 1'($urandom), 2'($urandom), byp, "R6 random mix");
        end

        // R7: an idle run holds the output
        for (int i = 0; i < 5; i++) step(0, 1'($urandom), 2'($urandom), 1'($urandom), "R7 idle run");

        finish_run();
    end

endmodule